// File: doc/BRIEF.md
# Hashed Forwarding Table Access Engine

This block gives host software access to a switch forwarding table through registers. The table is a set of hash buckets, and each bucket holds a fixed number of ways. Software works on one whole bucket at a time. It loads a lookup key, which is a 48-bit MAC index and a 16-bit VLAN index. It then writes a control register that holds a start/done flag and a direction bit. A read operation copies every way of the addressed bucket into staging registers. A write operation copies the staging registers back into that bucket.

Each way appears to software as two registers: a 64-bit MAC/VID word and a 32-bit data word. The engine does not interpret their fields. Software picks the way to use, resolves matches, and sets the valid, static, age, traffic class and port bits itself. The engine holds the start/done flag for a fixed number of cycles. It clears the flag when the bucket transfer completes, and software polls the flag.

Top module: `hash_tbl_engine`

## Requirements
- R1: After reset, the control register, both key registers and every staging register read as zero.
- R2: A control write with bit 7 set while the engine is idle starts an operation. Bit 7 of the control register reads 1 for exactly LATENCY cycles after that write's clock edge and then reads 0. Bit 0 reads back the direction.
- R3: An operation with direction bit 0 = 1 (read) loads the MAC/VID and data words of every way of the addressed bucket into the staging registers.
- R4: An operation with direction bit 0 = 0 (write) stores all staging ways into the bucket selected by the key held when the operation started.
- R5: The bucket index has IDX_W = log2(BUCKETS) bits. Index bit j is the XOR of all bits k of the 60-bit key {VLAN[11:0], MAC[47:0]} for which k mod IDX_W = j. Two keys with the same index address the same bucket.
- R6: While bit 7 is set, a further control write has no effect. The operation keeps its direction and its completion time.
- R7: While bit 7 is set, writes to the staging registers are discarded.
- R8: A read of a bucket that has never been written since reset returns zero in every staging word.
- R9: The register map is: control at 0x00 (bits 7 and 0 only), MAC index at 0x02 (48 bits), VLAN index at 0x08 (16 bits), and way n's MAC/VID word at 0x10+0x10·n with its data word at 0x18+0x10·n. Unused bits and unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_waddr | input | 8 | Register write address |
| reg_wdata | input | 64 | Register write data |
| reg_raddr | input | 8 | Register read address |
| reg_rdata | output | 64 | Register read data (combinational) |

## Verification
The bench writes a full set of keys across a 16-bucket, 4-way table and reads every one back. It also reads an aliased key that must hash to the same bucket. A wrong fold would return another bucket's contents, and a wrong way mapping would swap words between ways. The bench counts the busy cycles exactly and fires a second start and a staging write while the engine is busy. A design that restarts, flips direction or accepts the staging write would show a longer busy window, a read-back direction of 1, or a corrupted bucket. A bucket that was never written must read as zeros, which catches leftover staging data or uninitialised storage.

// File: rtl/hash_tbl_engine.sv
module hash_tbl_engine #(
  parameter int BUCKETS = 256,
  parameter int WAYS    = 4,
  parameter int LATENCY = 3
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        reg_we,
  input  logic [7:0]  reg_waddr,
  input  logic [63:0] reg_wdata,
  input  logic [7:0]  reg_raddr,
  output logic [63:0] reg_rdata
);
  localparam int IDX_W    = $clog2(BUCKETS);
  localparam int CNT_W    = $clog2(LATENCY + 1);
  localparam int KEY_W    = 60;
  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_MAC  = 8'h02;
  localparam logic [7:0] A_VID  = 8'h08;
  localparam int ENT_BASE = 16;
  localparam int ENT_STEP = 16;

  logic                       busy, dir;
  logic [CNT_W-1:0]           cnt;
  logic [47:0]                mac_idx;
  logic [15:0]                vid_idx;
  logic [IDX_W-1:0]           op_bkt;
  logic [WAYS-1:0][63:0]      stage_mv;
  logic [WAYS-1:0][31:0]      stage_dt;
  logic [WAYS-1:0][63:0]      tbl_mv [BUCKETS];
  logic [WAYS-1:0][31:0]      tbl_dt [BUCKETS];
  logic [BUCKETS-1:0]         bkt_vld;

  function automatic logic [IDX_W-1:0] bucket_of(input logic [47:0] m, input logic [11:0] v);
    logic [KEY_W-1:0] k;
    logic [IDX_W-1:0] h;
    k = {v, m};
    h = '0;
    for (int b = 0; b < KEY_W; b++) h[b % IDX_W] = h[b % IDX_W] ^ k[b];
    return h;
  endfunction

  wire ctrl_wr  = reg_we && reg_waddr == A_CTRL;
  wire start    = ctrl_wr && reg_wdata[7] && !busy;
  wire finish   = busy && cnt == CNT_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy    <= 1'b0;
      dir     <= 1'b0;
      cnt     <= '0;
      mac_idx <= '0;
      vid_idx <= '0;
      op_bkt  <= '0;
    end else begin
      if (reg_we && reg_waddr == A_MAC) mac_idx <= reg_wdata[47:0];
      if (reg_we && reg_waddr == A_VID) vid_idx <= reg_wdata[15:0];
      if (start) begin
        busy   <= 1'b1;
        dir    <= reg_wdata[0];
        cnt    <= CNT_W'(LATENCY);
        op_bkt <= bucket_of(mac_idx, vid_idx[11:0]);
      end else if (busy) begin
        cnt <= cnt - CNT_W'(1);
        if (finish) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_mv <= '0;
      stage_dt <= '0;
    end else if (finish && dir) begin
      stage_mv <= bkt_vld[op_bkt] ? tbl_mv[op_bkt] : '0;
      stage_dt <= bkt_vld[op_bkt] ? tbl_dt[op_bkt] : '0;
    end else if (reg_we && !busy) begin
      for (int w = 0; w < WAYS; w++) begin
        if (reg_waddr == 8'(ENT_BASE + w * ENT_STEP))     stage_mv[w] <= reg_wdata;
        if (reg_waddr == 8'(ENT_BASE + w * ENT_STEP + 8)) stage_dt[w] <= reg_wdata[31:0];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bkt_vld <= '0;
    else if (finish && !dir) bkt_vld[op_bkt] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (finish && !dir) begin
      tbl_mv[op_bkt] <= stage_mv;
      tbl_dt[op_bkt] <= stage_dt;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_raddr == A_CTRL) reg_rdata = {56'b0, busy, 6'b0, dir};
    if (reg_raddr == A_MAC)  reg_rdata = {16'b0, mac_idx};
    if (reg_raddr == A_VID)  reg_rdata = {48'b0, vid_idx};
    for (int w = 0; w < WAYS; w++) begin
      if (reg_raddr == 8'(ENT_BASE + w * ENT_STEP))     reg_rdata = stage_mv[w];
      if (reg_raddr == 8'(ENT_BASE + w * ENT_STEP + 8)) reg_rdata = {32'b0, stage_dt[w]};
    end
  end

  AST_START_SETS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_we && reg_waddr == A_CTRL && reg_wdata[7] && !busy) |=> busy); // R2
  AST_BUSY_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CNT_W'(1)) |=> busy); // R2
  AST_IDLE_CNT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> cnt == '0); // R2
  AST_DIR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(dir))); // R6
  AST_STAGE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && cnt != CNT_W'(1)) |=> ($stable(stage_mv) && $stable(stage_dt))); // R7
  AST_BKT_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    busy |=> (!busy || $stable(op_bkt))); // R4
endmodule

// File: tb/hash_tbl_engine_bench.sv
module hash_tbl_engine_bench;
  localparam int CLK_PERIOD = 10;
  localparam int BUCKETS = 16;
  localparam int WAYS    = 4;
  localparam int LATENCY = 3;
  localparam int IDX_W   = 4;

  logic clk = 0, rst_n = 0, reg_we = 0;
  logic [7:0] reg_waddr = 0, reg_raddr = 0;
  logic [63:0] reg_wdata = 0, reg_rdata;
  int n_tests = 0, n_fail = 0;
  logic [63:0] ref_mv [BUCKETS][WAYS];
  logic [31:0] ref_dt [BUCKETS][WAYS];

  always #(CLK_PERIOD/2) clk = ~clk;

  hash_tbl_engine #(.BUCKETS(BUCKETS), .WAYS(WAYS), .LATENCY(LATENCY)) u_hash_tbl_engine (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_waddr(reg_waddr),
    .reg_wdata(reg_wdata), .reg_raddr(reg_raddr), .reg_rdata(reg_rdata));

  function automatic logic [IDX_W-1:0] hsh(input logic [47:0] m, input logic [11:0] v);
    logic [59:0] k = {v, m};
    logic [IDX_W-1:0] h = '0;
    for (int b = 0; b < 60; b++) h[b % IDX_W] ^= k[b];
    return h;
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1; reg_waddr = a; reg_wdata = d;
    @(posedge clk); #1;
    reg_we = 0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [63:0] d);
    @(negedge clk);
    reg_raddr = a; #1;
    d = reg_rdata;
  endtask

  task automatic poll(output int busy_n);
    logic [63:0] d;
    busy_n = 0;
    for (int i = 0; i < 100; i++) begin
      rd(8'h00, d);
      if (!d[7]) break;
      busy_n++;
    end
  endtask

  task automatic run_op(input logic rd_dir);
    int n;
    wr(8'h00, {56'b0, 7'h40, rd_dir} | 64'h80);
    poll(n);
  endtask

  task automatic set_key(input logic [47:0] m, input logic [15:0] v);
    wr(8'h02, {16'b0, m});
    wr(8'h08, {48'b0, v});
  endtask

  function automatic logic [63:0] pat_mv(input int i, input int w);
    return {4'h0, 12'(i * 3 + w), 48'(i * 48'h10101 + w * 48'h0F0F0F)};
  endfunction
  function automatic logic [31:0] pat_dt(input int i, input int w);
    return 32'h0001_0000 | 32'(w << 11) | 32'(i);
  endfunction

  task automatic check_stage(input string req, input int b);
    logic [63:0] d;
    for (int w = 0; w < WAYS; w++) begin
      rd(8'(16 + w * 16), d);     chk(req, d, ref_mv[b][w]);
      rd(8'(16 + w * 16 + 8), d); chk(req, d, {32'b0, ref_dt[b][w]});
    end
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [63:0] d;
    logic [47:0] m;
    logic [11:0] v;
    logic [IDX_W-1:0] h;
    int n;
    for (int b = 0; b < BUCKETS; b++)
      for (int w = 0; w < WAYS; w++) begin ref_mv[b][w] = 0; ref_dt[b][w] = 0; end
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset state
    rd(8'h00, d); chk("R1 ctrl", d, 0);
    rd(8'h02, d); chk("R1 mac", d, 0);
    rd(8'h08, d); chk("R1 vid", d, 0);
    check_stage("R1 stage", 0);

    // R9 register map and masking
    wr(8'h02, 64'hFFFF_0123_4567_89AB); rd(8'h02, d); chk("R9 mac", d, 64'h0000_0123_4567_89AB);
    wr(8'h08, 64'hFFFF_FFFF_FFFF_ABCD); rd(8'h08, d); chk("R9 vid", d, 64'hABCD);
    wr(8'h38, 64'hFFFF_FFFF_1234_5678); rd(8'h38, d); chk("R9 data way2", d, 64'h1234_5678);
    rd(8'h50, d); chk("R9 unmapped", d, 0);

    // R8 untouched bucket reads zero, R2 busy window
    for (int w = 0; w < WAYS; w++) wr(8'(16 + w * 16), 64'hDEAD_BEEF_0000_0000 | 64'(w));
    wr(8'h00, 64'h81);
    poll(n);
    chk("R2 busy cycles read", 64'(n), 64'(LATENCY));
    rd(8'h00, d); chk("R2 dir readback", d, 64'h01);
    check_stage("R8 empty bucket", 0);

    // R4/R3 sweep over keys
    for (int i = 0; i < 16; i++) begin
      m = 48'h0A0B_0000_0000 ^ 48'(i * 48'h1357_9BDF);
      v = 12'(i * 7);
      h = hsh(m, v);
      set_key(m, {4'hF, v});
      for (int w = 0; w < WAYS; w++) begin
        wr(8'(16 + w * 16), pat_mv(i, w));
        wr(8'(16 + w * 16 + 8), {32'b0, pat_dt(i, w)});
        ref_mv[h][w] = pat_mv(i, w);
        ref_dt[h][w] = pat_dt(i, w);
      end
      wr(8'h00, 64'h80);
      poll(n);
      chk("R2 busy cycles write", 64'(n), 64'(LATENCY));
    end
    for (int i = 0; i < 16; i++) begin
      m = 48'h0A0B_0000_0000 ^ 48'(i * 48'h1357_9BDF);
      v = 12'(i * 7);
      set_key(m, {4'h0, v});
      run_op(1'b1);
      check_stage("R3 read back", int'(hsh(m, v)));
      // R5 aliased key (bits 0 and 4 fold to the same index bit)
      set_key(m ^ 48'h11, {4'h0, v});
      run_op(1'b1);
      check_stage("R5 alias", int'(hsh(m, v)));
      set_key(m ^ 48'h1, {4'h0, v});
      run_op(1'b1);
      check_stage("R5 neighbour", int'(hsh(m ^ 48'h1, v)));
    end

    // R6 second start during busy is ignored
    m = 48'h0000_0000_0003; v = 0; h = hsh(m, v);
    set_key(m, 16'h0);
    for (int w = 0; w < WAYS; w++) begin
      wr(8'(16 + w * 16), pat_mv(40, w)); wr(8'(16 + w * 16 + 8), {32'b0, pat_dt(40, w)});
      ref_mv[h][w] = pat_mv(40, w); ref_dt[h][w] = pat_dt(40, w);
    end
    wr(8'h00, 64'h80);
    wr(8'h00, 64'h81);
    rd(8'h00, d); chk("R6 dir unchanged", d, 64'h80);
    poll(n);
    chk("R6 completion time", 64'(n + 2), 64'(LATENCY));
    check_stage("R6 staging kept", int'(h));

    // R7 staging write during busy is dropped
    wr(8'h00, 64'h80);
    wr(8'h10, 64'h5555_5555_5555_5555);
    poll(n);
    rd(8'h10, d); chk("R7 staging held", d, ref_mv[h][0]);
    for (int w = 0; w < WAYS; w++) wr(8'(16 + w * 16), 64'h0);
    run_op(1'b1);
    check_stage("R7 bucket intact", int'(h));

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule